// File: doc/BRIEF.md
# Multi-layer video capture compositor

This block takes a 1-bit live video stream together with its pixel-clock timing (data-enable, horizontal and vertical sync). It can freeze one frame of that stream into any combination of four image layers. All four layers sit side by side in a single word-wide on-chip frame memory, with one byte lane per layer. A capture is therefore one byte-masked write per pixel, and the other layers are never read back and rewritten. The picture is stored at half resolution in both axes, so every stored pixel stands for a 2x2 block on screen.

During playback every layer is read at the current scan position and combined with the live pixel by a selectable logic operator. Each layer has its own mixed colour, and the result leaves the block as a 12-bit RGB pixel. The sync and enable signals come out delayed by one clock, so they stay aligned with the pixel.

Recording runs through a small state machine with three states: `REC_IDLE`, `REC_ARMED` and `REC_CAPTURE`. Its transitions are:

- **arm**: `REC_IDLE` to `REC_ARMED`, on a record strobe with a non-empty layer selection.
- **start**: `REC_ARMED` to `REC_CAPTURE`, on the next vsync rising edge.
- **stop**: `REC_CAPTURE` to `REC_IDLE`, on the following vsync rising edge.
- **hold**: every state keeps its value when neither event occurs. A strobe with an empty selection falls under hold.

Top module: `layer_compositor`

## Requirements
- R1: While reset is active and after it is released with idle inputs, `out_de`, `out_hs` and `out_vs` are 0 and all RGB outputs are 0.
- R2: Layer l occupies bits [8l+7:8l] of a memory word. A capture writes only the lanes selected by the latched layer mask, and every unselected lane keeps its earlier contents. A captured pixel is stored as its live bit replicated over the lane's 8 bits.
- R3: The word address of a pixel is (h >> 1) + (v >> 1) * COLS, where h and v are the pixel's position in the active area. The four pixels of a 2x2 block share one word, so the last one written in a block (odd h, odd v) is what the block holds.
- R4: The horizontal and vertical counters clear while vsync is high. They advance only on cycles with data-enable high, so a data-enable gap inside a line leaves the address sequence unbroken. The horizontal counter wraps after 2*COLS pixels and then the vertical counter steps.
- R5: A record strobe while the layer select is 0000 performs no write and leaves the recorder in `REC_IDLE`.
- R6: A strobe with a non-zero select in `REC_IDLE` arms the recorder. Capture runs from the next vsync rising edge to the one after it, so exactly one frame is written. Later frames write nothing.
- R7: The mix-mode codes are 0 = AND, 1 = OR, 2 = XOR and 3 = key. In the first three modes, layer l is lit when (layer bit op live bit) is 1. In key mode, the lit layers are shown where any layer is set. Where no layer is set, key mode shows the live pixel as white (FFF) or black.
- R8: The layer colours in {R,G,B} nibbles are: layer 0 = 8,4,0; layer 1 = 0,8,4; layer 2 = 4,0,8; layer 3 = 2,2,2. The output is the bitwise OR of the colours of all lit layers.
- R9: `out_de`, `out_hs` and `out_vs` equal the corresponding inputs delayed by one clock. The RGB output matches the pixel presented on that earlier clock, and it is 0 whenever `out_de` is 0.
- R10: Strobes in `REC_ARMED` or `REC_CAPTURE` are ignored. The layer mask is latched at the arm transition, and later changes of the select inputs do not alter which lanes the capture writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_de | input | 1 | Live data-enable (active area) |
| pix_hs | input | 1 | Live horizontal sync |
| pix_vs | input | 1 | Live vertical sync, active high |
| live_px | input | 1 | Live 1-bit pixel |
| rec_strobe | input | 1 | One-clock record request |
| layer_sel | input | LAYERS | Layers to capture into, one bit per layer |
| mix_mode | input | 2 | Playback operator code |
| out_de | output | 1 | Data-enable, delayed one clock |
| out_hs | output | 1 | Horizontal sync, delayed one clock |
| out_vs | output | 1 | Vertical sync, delayed one clock |
| out_r | output | 4 | Red component |
| out_g | output | 4 | Green component |
| out_b | output | 4 | Blue component |

## Verification
The assertions watch the recorder's transitions on every cycle:

- Arming happens only with a non-empty selection, and an empty-select strobe never leaves `REC_IDLE`.
- The recorder starts and stops on vsync edges, and the mask stays frozen while armed or capturing.
- The counters stay in range and clear under vsync.
- The one-clock alignment of the sync outputs holds, and the output is black outside data-enable.

Only the bench's frame scenarios can show what actually lands in memory. Those scenarios cover lane isolation across successive captures, the 2x2 sharing of a stored pixel, capture of exactly one frame, and each of the four mix operators with the layer colours. The bench checks all of these against its own model of the stored layers.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;

    typedef enum logic [1:0] {
        MIX_AND = 2'd0,
        MIX_OR  = 2'd1,
        MIX_XOR = 2'd2,
        MIX_KEY = 2'd3
    } mix_mode_e;

    typedef enum logic [1:0] {
        REC_IDLE    = 2'd0,
        REC_ARMED   = 2'd1,
        REC_CAPTURE = 2'd2
    } rec_state_e;

    // {R,G,B} nibbles; the four values use disjoint bits per component
    function automatic logic [11:0] layer_colour(input int unsigned idx);
        unique case (idx % 4)
            0:       layer_colour = 12'h840;
            1:       layer_colour = 12'h084;
            2:       layer_colour = 12'h408;
            default: layer_colour = 12'h222;
        endcase
    endfunction

endpackage

// File: rtl/lc_scan_counter.sv
`timescale 1ns/1ps
module lc_scan_counter #(
    parameter int COLS = 40,
    parameter int ROWS = 30,
    parameter int AW   = 11,
    localparam int ACT_W = 2 * COLS,
    localparam int ACT_H = 2 * ROWS,
    localparam int HW    = $clog2(ACT_W + 1),
    localparam int VW    = $clog2(ACT_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          de,
    input  logic          vs,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic [AW-1:0] addr,
    output logic          in_range
);
    localparam logic [HW-1:0] H_LAST = HW'(ACT_W - 1);
    localparam logic [VW-1:0] V_END  = VW'(ACT_H);
    localparam logic [AW-1:0] STRIDE = AW'(COLS);

    always_ff @(posedge clk) begin
        if (!rst_n || vs) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (de) begin
            if (h_cnt == H_LAST) begin
                h_cnt <= '0;
                if (v_cnt != V_END) v_cnt <= v_cnt + 1'b1;
            end else begin
                h_cnt <= h_cnt + 1'b1;
            end
        end
    end

    assign addr     = AW'(h_cnt >> 1) + AW'(v_cnt >> 1) * STRIDE;
    assign in_range = (v_cnt != V_END);
endmodule

// File: rtl/lc_rec_fsm.sv
`timescale 1ns/1ps
module lc_rec_fsm
    import lc_pkg::*;
#(
    parameter int LAYERS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [LAYERS-1:0] sel,
    input  logic              vs,
    output rec_state_e        state,
    output logic [LAYERS-1:0] mask,
    output logic              vs_rise,
    output logic              capture
);
    rec_state_e next_state;
    logic       vs_d;

    assign vs_rise = vs && !vs_d;

    always_comb begin
        next_state = state;
        unique case (state)
            REC_IDLE:    if (strobe && (sel != '0)) next_state = REC_ARMED;
            REC_ARMED:   if (vs_rise)               next_state = REC_CAPTURE;
            REC_CAPTURE: if (vs_rise)               next_state = REC_IDLE;
            default:                                next_state = REC_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= REC_IDLE;
            mask  <= '0;
            vs_d  <= 1'b0;
        end else begin
            state <= next_state;
            vs_d  <= vs;
            if (state == REC_IDLE && next_state == REC_ARMED) mask <= sel;
        end
    end

    // output process
    always_comb begin
        capture = 1'b0;
        unique case (state)
            REC_CAPTURE: capture = 1'b1;
            default:     capture = 1'b0;
        endcase
    end
endmodule

// File: rtl/lc_frame_mem.sv
`timescale 1ns/1ps
module lc_frame_mem #(
    parameter int WORDS  = 1200,
    parameter int LAYERS = 4,
    parameter int LANE_W = 8,
    parameter int AW     = 11,
    localparam int DW    = LAYERS * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LAYERS-1:0] be,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LAYERS; l++) begin
            if (we && be[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/lc_mixer.sv
`timescale 1ns/1ps
module lc_mixer
    import lc_pkg::*;
#(
    parameter int LAYERS = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LAYERS * LANE_W
) (
    input  logic [DW-1:0] word,
    input  logic          live,
    input  logic          de,
    input  mix_mode_e     mode,
    output logic [3:0]    r,
    output logic [3:0]    g,
    output logic [3:0]    b
);
    logic [11:0] acc;
    logic        any_set;

    always_comb begin
        acc     = '0;
        any_set = 1'b0;
        for (int l = 0; l < LAYERS; l++) begin
            logic s, lit;
            s = |word[l*LANE_W +: LANE_W];
            unique case (mode)
                MIX_AND: lit = s & live;
                MIX_OR:  lit = s | live;
                MIX_XOR: lit = s ^ live;
                default: lit = s;
            endcase
            if (lit) acc = acc | layer_colour(l);
            any_set = any_set | s;
        end
        if (mode == MIX_KEY && !any_set) acc = live ? 12'hFFF : 12'h000;
        if (!de) acc = '0;
    end

    assign {r, g, b} = acc;
endmodule

// File: rtl/layer_compositor.sv
`timescale 1ns/1ps
module layer_compositor
    import lc_pkg::*;
#(
    parameter int COLS   = 40,
    parameter int ROWS   = 30,
    parameter int LAYERS = 4,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_de,
    input  logic              pix_hs,
    input  logic              pix_vs,
    input  logic              live_px,
    input  logic              rec_strobe,
    input  logic [LAYERS-1:0] layer_sel,
    input  logic [1:0]        mix_mode,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs,
    output logic [3:0]        out_r,
    output logic [3:0]        out_g,
    output logic [3:0]        out_b
);
    localparam int WORDS = COLS * ROWS;
    localparam int AW    = $clog2(WORDS);
    localparam int DW    = LAYERS * LANE_W;
    localparam int HW    = $clog2(2 * COLS + 1);
    localparam int VW    = $clog2(2 * ROWS + 1);

    logic [HW-1:0]     h_cnt;
    logic [VW-1:0]     v_cnt;
    logic [AW-1:0]     addr;
    logic              in_range;
    rec_state_e        rec_state;
    logic [LAYERS-1:0] rec_mask;
    logic              vs_rise;
    logic              capture;
    logic              mem_we;
    logic [DW-1:0]     wr_word;
    logic [DW-1:0]     rd_word;
    logic              live_q;
    logic [1:0]        mode_q;

    lc_scan_counter #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) scan_i (
        .clk(clk), .rst_n(rst_n), .de(pix_de), .vs(pix_vs),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .addr(addr), .in_range(in_range)
    );

    lc_rec_fsm #(.LAYERS(LAYERS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .strobe(rec_strobe), .sel(layer_sel),
        .vs(pix_vs), .state(rec_state), .mask(rec_mask),
        .vs_rise(vs_rise), .capture(capture)
    );

    assign mem_we  = capture && pix_de && !pix_vs && in_range;
    assign wr_word = {LAYERS{{LANE_W{live_px}}}};

    lc_frame_mem #(.WORDS(WORDS), .LAYERS(LAYERS), .LANE_W(LANE_W), .AW(AW)) mem_i (
        .clk(clk), .we(mem_we), .be(rec_mask), .addr(addr),
        .wdata(wr_word), .rdata(rd_word)
    );

    // one-clock alignment stage matching the memory read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_de <= 1'b0;
            out_hs <= 1'b0;
            out_vs <= 1'b0;
            live_q <= 1'b0;
            mode_q <= 2'd0;
        end else begin
            out_de <= pix_de;
            out_hs <= pix_hs;
            out_vs <= pix_vs;
            live_q <= live_px;
            mode_q <= mix_mode;
        end
    end

    lc_mixer #(.LAYERS(LAYERS), .LANE_W(LANE_W)) mix_i (
        .word(rd_word), .live(live_q), .de(out_de), .mode(mix_mode_e'(mode_q)),
        .r(out_r), .g(out_g), .b(out_b)
    );
endmodule

// File: rtl/lc_checker.sv
`timescale 1ns/1ps
module lc_checker
    import lc_pkg::*;
#(
    parameter int COLS   = 40,
    parameter int ROWS   = 30,
    parameter int LAYERS = 4,
    localparam int HW    = $clog2(2 * COLS + 1),
    localparam int VW    = $clog2(2 * ROWS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_de,
    input logic              pix_hs,
    input logic              pix_vs,
    input logic              out_de,
    input logic              out_hs,
    input logic              out_vs,
    input logic [11:0]       rgb,
    input logic              rec_strobe,
    input logic [LAYERS-1:0] layer_sel,
    input rec_state_e        state,
    input logic [LAYERS-1:0] mask,
    input logic              vs_rise,
    input logic [HW-1:0]     h_cnt,
    input logic [VW-1:0]     v_cnt
);
    localparam logic [HW-1:0] H_WIDTH = HW'(2 * COLS);

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_de == $past(pix_de) && out_hs == $past(pix_hs) && out_vs == $past(pix_vs))); // R9
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (rgb == 12'h000)); // R9
    AST_EMPTY_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REC_IDLE && rec_strobe && layer_sel == '0) |=> (state == REC_IDLE)); // R5
    AST_ARM_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REC_IDLE && rec_strobe && layer_sel != '0) |=> (state == REC_ARMED)); // R6
    AST_START_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REC_ARMED && vs_rise) |=> (state == REC_CAPTURE)); // R6
    AST_STOP_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REC_CAPTURE && vs_rise) |=> (state == REC_IDLE)); // R6
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REC_CAPTURE) |-> (mask != '0)); // R2
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != REC_IDLE) |=> (state == REC_IDLE || $stable(mask))); // R10
    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt < H_WIDTH); // R4
    AST_VSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_vs)) |-> (h_cnt == '0 && v_cnt == '0)); // R4
endmodule

bind layer_compositor lc_checker #(.COLS(COLS), .ROWS(ROWS), .LAYERS(LAYERS)) chk_i (
    .clk(clk), .rst_n(rst_n), .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .rgb({out_r, out_g, out_b}),
    .rec_strobe(rec_strobe), .layer_sel(layer_sel), .state(rec_state), .mask(rec_mask),
    .vs_rise(vs_rise), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/layer_compositor_tb_top.sv
`timescale 1ns/1ps
module layer_compositor_tb_top;
    localparam int COLS  = 8;
    localparam int ROWS  = 6;
    localparam int ACT_W = 2 * COLS;
    localparam int ACT_H = 2 * ROWS;
    localparam int WORDS = COLS * ROWS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_de = 0, pix_hs = 0, pix_vs = 0, live_px = 0, rec_strobe = 0;
    logic [3:0] layer_sel = 4'h0;
    logic [1:0] mix_mode = 2'd0;
    logic out_de, out_hs, out_vs;
    logic [3:0] out_r, out_g, out_b;

    always #5 clk = ~clk;

    layer_compositor #(.COLS(COLS), .ROWS(ROWS), .LAYERS(4), .LANE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs),
        .live_px(live_px), .rec_strobe(rec_strobe), .layer_sel(layer_sel),
        .mix_mode(mix_mode), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model of stored layers
    logic [3:0] mdl [WORDS];
    logic [3:0] mknown [WORDS];
    int bh = 0, bv = 0, bstate = 0;
    logic [3:0] bmask = 4'h0;
    logic pvs = 0;
    logic [3:0] sel_v = 4'h0;
    int mode_v = 0;

    // pending expectation for the pixel driven on the previous cycle
    bit pend = 0, e_known = 0;
    logic e_de, e_hs, e_vs;
    logic [11:0] e_rgb;
    int pix_mism = 0, sync_mism = 0;
    logic [31:0] p_act, p_exp, s_act, s_exp;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] colour_of(input int l);
        case (l)
            0: return 12'h840;
            1: return 12'h084;
            2: return 12'h408;
            default: return 12'h222;
        endcase
    endfunction

    function automatic logic [11:0] exp_mix(input logic [3:0] lay, input logic live, input int mode);
        logic [11:0] c = 12'h000;
        if (mode == 3 && lay == 4'h0) return live ? 12'hFFF : 12'h000;
        for (int l = 0; l < 4; l++) begin
            logic lit;
            case (mode)
                0: lit = lay[l] & live;
                1: lit = lay[l] | live;
                2: lit = lay[l] ^ live;
                default: lit = lay[l];
            endcase
            if (lit) c = c | colour_of(l);
        end
        return c;
    endfunction

    function automatic logic pattern(input int id, input int x, input int y);
        case (id)
            0: return 1'b0;
            1: return 1'b1;
            2: return (x < ACT_W / 2);
            3: return 1'(((x >> 1) ^ (y >> 1)) & 1);
            4: return 1'(x & y & 1);
            default: return 1'(((x >> 2) ^ (y >> 2)) & 1);
        endcase
    endfunction

    task automatic drive_cycle(input logic de, input logic hs, input logic vs, input logic live, input logic rec);
        int a;
        @(negedge clk);
        if (pend) begin
            if ({out_de, out_hs, out_vs} != {e_de, e_hs, e_vs}) begin
                if (sync_mism == 0) begin
                    s_act = {29'd0, out_de, out_hs, out_vs};
                    s_exp = {29'd0, e_de, e_hs, e_vs};
                end
                sync_mism++;
            end
            if (e_known && {out_r, out_g, out_b} != e_rgb) begin
                if (pix_mism == 0) begin
                    p_act = {20'd0, out_r, out_g, out_b};
                    p_exp = {20'd0, e_rgb};
                end
                pix_mism++;
            end
        end
        e_de = de; e_hs = hs; e_vs = vs; e_known = 1'b1; e_rgb = 12'h000;
        if (de && !vs) begin
            a = (bh >> 1) + (bv >> 1) * COLS;
            e_known = (mknown[a] == 4'hF);
            e_rgb = exp_mix(mdl[a], live, mode_v);
            if (bstate == 2) begin
                for (int l = 0; l < 4; l++) begin
                    if (bmask[l]) begin
                        mdl[a][l] = live;
                        mknown[a][l] = 1'b1;
                    end
                end
            end
        end
        pend = 1;
        if (vs) begin
            bh = 0; bv = 0;
        end else if (de) begin
            if (bh == ACT_W - 1) begin
                bh = 0;
                if (bv < ACT_H) bv++;
            end else bh++;
        end
        if (rec && bstate == 0 && sel_v != 4'h0) begin
            bstate = 1; bmask = sel_v;
        end else if (vs && !pvs) begin
            if (bstate == 1) bstate = 2;
            else if (bstate == 2) bstate = 0;
        end
        pvs = vs;
        pix_de = de; pix_hs = hs; pix_vs = vs; live_px = live; rec_strobe = rec;
        layer_sel = sel_v; mix_mode = 2'(mode_v);
    endtask

    task automatic run_frame(input int pat, input bit gap);
        pix_mism = 0; sync_mism = 0;
        for (int i = 0; i < 3; i++) drive_cycle(0, 0, 1, 0, 0);
        for (int i = 0; i < 2; i++) drive_cycle(0, 0, 0, 0, 0);
        for (int y = 0; y < ACT_H; y++) begin
            for (int i = 0; i < 4; i++) drive_cycle(0, (i < 2), 0, 0, 0);
            for (int x = 0; x < ACT_W; x++) begin
                if (gap && x == 5) begin
                    for (int i = 0; i < 3; i++) drive_cycle(0, 0, 0, 1, 0);
                end
                drive_cycle(1, 0, 0, pattern(pat, x, y), 0);
            end
        end
        for (int i = 0; i < 2; i++) drive_cycle(0, 0, 0, 0, 0);
    endtask

    task automatic frame_done(input string tag);
        check(pix_mism == 0, tag, p_act, p_exp);
        check(sync_mism == 0, {"R9 delayed sync/de in: ", tag}, s_act, s_exp);
    endtask

    task automatic strobe(input logic [3:0] sel);
        sel_v = sel;
        drive_cycle(0, 0, 0, 0, 1);
        drive_cycle(0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(out_de == 0 && out_hs == 0 && out_vs == 0, "R1 syncs low in reset", {out_de, out_hs, out_vs}, 0);
        check({out_r, out_g, out_b} == 12'h000, "R1 rgb black in reset", {out_r, out_g, out_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_de, out_r, out_g, out_b} == 13'd0, "R1 idle after release", {out_de, out_r, out_g, out_b}, 0);
    endtask

    task automatic t_clear();
        strobe(4'hF);
        run_frame(0, 0);
        frame_done("R2 clear capture of all lanes");
        mode_v = 1;
        run_frame(0, 0);
        frame_done("R2 cleared layers read zero");
    endtask

    task automatic t_lanes();
        strobe(4'h1);
        run_frame(2, 0);
        frame_done("R2 capture into lane 0");
        mode_v = 1;
        run_frame(0, 0);
        frame_done("R2 lane 0 holds pattern");
        strobe(4'h4);
        run_frame(3, 0);
        frame_done("R2 capture into lane 2");
        run_frame(0, 0);
        frame_done("R2 lane 0 kept after lane 2 write");
        mode_v = 0;
        run_frame(1, 0);
        frame_done("R8 layer colours under AND with live 1");
    endtask

    task automatic t_halfres();
        strobe(4'h8);
        run_frame(4, 0);
        frame_done("R3 capture of sparse pattern");
        mode_v = 0;
        run_frame(1, 0);
        frame_done("R3 2x2 block keeps odd/odd pixel");
    endtask

    task automatic t_empty();
        strobe(4'h0);
        mode_v = 1;
        run_frame(1, 0);
        frame_done("R5 empty select frame shows no capture");
        run_frame(0, 0);
        frame_done("R5 empty select wrote nothing");
    endtask

    task automatic t_one_frame();
        strobe(4'h2);
        strobe(4'h8);
        sel_v = 4'hF;
        run_frame(5, 0);
        frame_done("R10 capture uses latched lane 1 mask");
        run_frame(1, 0);
        frame_done("R6 frame after capture");
        mode_v = 1;
        run_frame(0, 0);
        frame_done("R6 only one frame written, R10 other lanes intact");
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            mode_v = m;
            run_frame(3, 0);
            frame_done($sformatf("R7 mode %0d live checker", m));
        end
        mode_v = 3;
        run_frame(1, 0);
        frame_done("R7 key mode live 1");
        run_frame(0, 0);
        frame_done("R7 key mode live 0");
    endtask

    task automatic t_gap();
        mode_v = 2;
        run_frame(5, 1);
        frame_done("R4 de gap keeps address sequence");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mdl[i] = 4'h0;
            mknown[i] = 4'h0;
        end
        t_reset();
        t_clear();
        t_lanes();
        t_halfres();
        t_empty();
        t_one_frame();
        t_modes();
        t_gap();
        drive_cycle(0, 0, 0, 0, 0);
        done = 1;
        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end
endmodule